// File: doc/BRIEF.md
# Transition Counting Sample Averager

This block sits behind a sampling row of flip-flops that is captured once per test step. Each captured row snapshot arrives over a valid/ready stream together with the phase-shift setting used for that capture and a flag that marks the last snapshot of a sweep. A 17-bit window of the row is selected at a zero-based base position. The 16 neighbouring bit pairs of that window are compared, and the number of differing pairs is reported both in full and clipped to four bits.

Within each sweep the block watches one chosen pair of the window, the tracked pair. The sweep's sample is the phase setting of the first snapshot in which that pair differs. If the pair never differs, the sample is the phase of the sweep's closing snapshot. A run starts with a start pulse and covers a power-of-two number of sweeps. The samples are summed and the average is formed with a right shift only. When the run ends, the average is presented with a one-cycle valid pulse, together with the spread (largest minus smallest sample) and a flag that shows whether the spread is above a limit input.

The snapshot stream obeys these back-pressure rules. `snap_ready` is high only while a run is active and `start` is low. A transfer happens on a rising clock edge where `snap_valid` and `snap_ready` are both high. A source that holds `snap_valid` high while `snap_ready` is low must keep its payload unchanged. Snapshots are never accepted between runs.

Top module: `tcnt_avg_top`

## Requirements
- R1: The inspected window is bits `base_pos+16` down to `base_pos` of `snap_row`. Window bit i is row bit `base_pos+i`, so `base_pos` 0 selects bits 16:0 and `base_pos` 255 selects bits 271:255.
- R2: On the edge after an accepted snapshot, `pair_diff_count` equals the number of indices i in 0..15 for which window bit i differs from window bit i+1. On that same edge `pair_diff_clip` equals that number clipped to 15. Both outputs hold their values while no snapshot is accepted.
- R3: `snap_ready` is high exactly when a run is active and `start` is low. A snapshot offered while `snap_ready` is low has no effect on any output.
- R4: A `start` pulse clears the sum, the minimum and the maximum, and clears the tracked-pair history. It latches `log2_sweeps`, whose value k is 0..7, and begins a run of 2^k sweeps. The pulse takes priority over a snapshot in the same cycle. A start during a run abandons that run.
- R5: The sample of a sweep is the `snap_phase` of the first accepted snapshot of that sweep in which window bits `track_pair` and `track_pair+1` differ. If no such snapshot occurs, the sample is the `snap_phase` of the snapshot accepted with `snap_last` high.
- R6: In the cycle after the closing snapshot of the run's last sweep is accepted, `avg_valid` is high for exactly one cycle. In that cycle `avg_out` is floor(sum of the run's samples / 2^k). The run then ends, so `snap_ready` is low.
- R7: In the same cycle as R6, `spread_out` equals the largest sample minus the smallest sample of the run. `spread_over` is 1 exactly when `spread_out` is greater than `spread_limit` as sampled on the closing edge.
- R8: After reset, `snap_ready`, `avg_valid`, `avg_out`, `spread_out`, `spread_over`, `pair_diff_count` and `pair_diff_clip` are all 0. `avg_out`, `spread_out` and `spread_over` keep their values until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a run |
| log2_sweeps | input | 3 | log2 of the number of sweeps in a run, latched at start |
| base_pos | input | 8 | Zero-based start of the inspected window |
| track_pair | input | 4 | Index of the tracked pair within the window |
| spread_limit | input | 11 | Limit against which the spread is compared |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Snapshot can be accepted |
| snap_row | input | 272 | Captured row |
| snap_phase | input | 11 | Phase setting of this capture |
| snap_last | input | 1 | Closing snapshot of the sweep |
| pair_diff_count | output | 5 | Differing pairs in the last accepted window |
| pair_diff_clip | output | 4 | Same count clipped to 15 |
| avg_out | output | 11 | Average sample of the last completed run |
| avg_valid | output | 1 | One-cycle pulse when a run completes |
| spread_out | output | 11 | Largest minus smallest sample of the last completed run |
| spread_over | output | 1 | Spread exceeds the limit |

## Verification
`snap_ready` is a combinational function of the run state and `start`, so it is due in the same cycle as its cause. The pair counts follow one edge after the accepting edge. The average, spread and valid pulse also follow one edge after the closing accept. The bench changes inputs one time unit after each rising edge. A behavioural model updates at every rising edge from those inputs, and the bench compares every output against the model at the next falling edge. Each check therefore looks at exactly the cycle in which its result is due. The scenarios cover both window ends, runs of 1 to 128 sweeps, sweeps with no tracked transition, idle offers, and a restart that arrives while a snapshot is offered.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  parameter int ROW_BASE  = 256;
  parameter int WIN_PAIRS = 16;
  parameter int PHASE_W   = 11;
  parameter int LOG_W     = 3;
endpackage

// File: rtl/tcnt_window.sv
module tcnt_window #(
  parameter int ROW_W = 272,
  parameter int WIN   = 17,
  parameter int POS_W = 8,
  parameter int TGT_W = 4,
  parameter int CNT_W = 5,
  parameter int CLP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [ROW_W-1:0] row,
  input  logic [POS_W-1:0] pos,
  input  logic [TGT_W-1:0] tgt,
  output logic             tgt_diff,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CLP_W-1:0] clip_q
);
  localparam int NPAIR = WIN - 1;
  localparam logic [CNT_W-1:0] CLIP_MAX = CNT_W'((1 << CLP_W) - 1);

  logic [WIN-1:0]   win;
  logic [NPAIR-1:0] diff;
  logic [CNT_W-1:0] cnt;

  assign win = row[pos +: WIN];

  genvar gi;
  generate
    for (gi = 0; gi < NPAIR; gi++) begin : g_pair
      assign diff[gi] = win[gi] ^ win[gi+1];
    end
  endgenerate

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NPAIR; i++) cnt = cnt + CNT_W'(diff[i]);
  end

  assign tgt_diff = diff[tgt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      clip_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt;
      clip_q <= (cnt > CLIP_MAX) ? CLIP_MAX[CLP_W-1:0] : cnt[CLP_W-1:0];
    end
  end
endmodule

// File: rtl/tcnt_sweep.sv
module tcnt_sweep #(
  parameter int PHASE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               take,
  input  logic               last,
  input  logic               hit,
  input  logic [PHASE_W-1:0] phase,
  output logic               sample_valid,
  output logic [PHASE_W-1:0] sample
);
  logic               seen_q;
  logic [PHASE_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      first_q <= '0;
    end else if (clear) begin
      seen_q  <= 1'b0;
    end else if (take) begin
      if (last) begin
        seen_q <= 1'b0;
      end else if (hit && !seen_q) begin
        seen_q  <= 1'b1;
        first_q <= phase;
      end
    end
  end

  // An earlier hit wins; otherwise the current phase (hit now or closing snapshot).
  assign sample       = seen_q ? first_q : phase;
  assign sample_valid = take && last;
endmodule

// File: rtl/tcnt_accum.sv
module tcnt_accum #(
  parameter int PHASE_W = 11,
  parameter int LOG_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LOG_W-1:0]   log_in,
  input  logic [PHASE_W-1:0] limit,
  input  logic               add,
  input  logic [PHASE_W-1:0] sample,
  output logic               active,
  output logic [PHASE_W-1:0] avg,
  output logic               avg_valid,
  output logic [PHASE_W-1:0] spread,
  output logic               over
);
  localparam int SAM_W = 1 << LOG_W;
  localparam int ACC_W = PHASE_W + SAM_W;

  logic [LOG_W-1:0]   log_q;
  logic [SAM_W:0]     done_q, done_n, need;
  logic [ACC_W-1:0]   acc_q, acc_n;
  logic [PHASE_W-1:0] mn_q, mx_q, mn_n, mx_n, spr_n;
  logic               final_n;

  assign need    = (SAM_W+1)'(1) << log_q;
  assign done_n  = done_q + 1'b1;
  assign acc_n   = acc_q + ACC_W'(sample);
  assign mn_n    = (sample < mn_q) ? sample : mn_q;
  assign mx_n    = (sample > mx_q) ? sample : mx_q;
  assign spr_n   = mx_n - mn_n;
  assign final_n = add && (done_n == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      log_q     <= '0;
      done_q    <= '0;
      acc_q     <= '0;
      mn_q      <= '1;
      mx_q      <= '0;
      avg       <= '0;
      avg_valid <= 1'b0;
      spread    <= '0;
      over      <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      log_q     <= log_in;
      done_q    <= '0;
      acc_q     <= '0;
      mn_q      <= '1;
      mx_q      <= '0;
      avg_valid <= 1'b0;
    end else begin
      avg_valid <= 1'b0;
      if (add) begin
        acc_q  <= acc_n;
        mn_q   <= mn_n;
        mx_q   <= mx_n;
        done_q <= done_n;
      end
      if (final_n) begin
        active    <= 1'b0;
        avg       <= PHASE_W'(acc_n >> log_q);
        spread    <= spr_n;
        over      <= spr_n > limit;
        avg_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcnt_avg_top.sv
module tcnt_avg_top
  import tcnt_pkg::*;
#(
  parameter int BASE_N  = ROW_BASE,
  parameter int PAIRS   = WIN_PAIRS,
  parameter int PH_W    = PHASE_W,
  parameter int LG_W    = LOG_W,
  localparam int ROW_W  = BASE_N + PAIRS,
  localparam int WIN    = PAIRS + 1,
  localparam int POS_W  = $clog2(BASE_N),
  localparam int TGT_W  = $clog2(PAIRS),
  localparam int CNT_W  = $clog2(PAIRS + 1),
  localparam int CLP_W  = CNT_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LG_W-1:0]  log2_sweeps,
  input  logic [POS_W-1:0] base_pos,
  input  logic [TGT_W-1:0] track_pair,
  input  logic [PH_W-1:0]  spread_limit,
  input  logic             snap_valid,
  output logic             snap_ready,
  input  logic [ROW_W-1:0] snap_row,
  input  logic [PH_W-1:0]  snap_phase,
  input  logic             snap_last,
  output logic [CNT_W-1:0] pair_diff_count,
  output logic [CLP_W-1:0] pair_diff_clip,
  output logic [PH_W-1:0]  avg_out,
  output logic             avg_valid,
  output logic [PH_W-1:0]  spread_out,
  output logic             spread_over
);
  logic             active, take, tgt_diff, smp_valid;
  logic [PH_W-1:0]  smp;

  assign snap_ready = active && !start;
  assign take       = snap_valid && snap_ready;

  tcnt_window #(
    .ROW_W(ROW_W), .WIN(WIN), .POS_W(POS_W), .TGT_W(TGT_W),
    .CNT_W(CNT_W), .CLP_W(CLP_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .take(take), .row(snap_row), .pos(base_pos),
    .tgt(track_pair), .tgt_diff(tgt_diff), .cnt_q(pair_diff_count),
    .clip_q(pair_diff_clip)
  );

  tcnt_sweep #(.PHASE_W(PH_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .clear(start), .take(take), .last(snap_last),
    .hit(tgt_diff), .phase(snap_phase), .sample_valid(smp_valid), .sample(smp)
  );

  tcnt_accum #(.PHASE_W(PH_W), .LOG_W(LG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .log_in(log2_sweeps),
    .limit(spread_limit), .add(smp_valid), .sample(smp), .active(active),
    .avg(avg_out), .avg_valid(avg_valid), .spread(spread_out),
    .over(spread_over)
  );
endmodule

// File: rtl/tcnt_checker.sv
module tcnt_checker #(
  parameter int PH_W  = 11,
  parameter int CNT_W = 5,
  parameter int CLP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             snap_ready,
  input logic [CNT_W-1:0] pair_diff_count,
  input logic [CLP_W-1:0] pair_diff_clip,
  input logic             avg_valid,
  input logic [PH_W-1:0]  spread_out,
  input logic             spread_over,
  input logic [PH_W-1:0]  spread_limit
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pair_diff_count <= CNT_W'(16));

  a_r2_clip_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_diff_count < CNT_W'(16)) |-> (CNT_W'(pair_diff_clip) == pair_diff_count));

  a_r4_start_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !snap_ready);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |=> !avg_valid);

  a_r6_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> !snap_ready);

  a_r7_over_flag: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> (spread_over == (spread_out > $past(spread_limit))));
endmodule

bind tcnt_avg_top tcnt_checker #(.PH_W(PH_W), .CNT_W(CNT_W), .CLP_W(CLP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .snap_ready(snap_ready),
  .pair_diff_count(pair_diff_count), .pair_diff_clip(pair_diff_clip),
  .avg_valid(avg_valid), .spread_out(spread_out), .spread_over(spread_over),
  .spread_limit(spread_limit)
);

// File: tb/tb_tcnt_avg_top.sv
module tb_tcnt_avg_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   log2_sweeps = '0;
  logic [7:0]   base_pos = '0;
  logic [3:0]   track_pair = '0;
  logic [10:0]  spread_limit = '0;
  logic         snap_valid = 1'b0;
  logic         snap_ready;
  logic [271:0] snap_row = '0;
  logic [10:0]  snap_phase = '0;
  logic         snap_last = 1'b0;
  logic [4:0]   pair_diff_count;
  logic [3:0]   pair_diff_clip;
  logic [10:0]  avg_out;
  logic         avg_valid;
  logic [10:0]  spread_out;
  logic         spread_over;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  tcnt_avg_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .log2_sweeps(log2_sweeps),
    .base_pos(base_pos), .track_pair(track_pair), .spread_limit(spread_limit),
    .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_row(snap_row),
    .snap_phase(snap_phase), .snap_last(snap_last),
    .pair_diff_count(pair_diff_count), .pair_diff_clip(pair_diff_clip),
    .avg_out(avg_out), .avg_valid(avg_valid), .spread_out(spread_out),
    .spread_over(spread_over)
  );

  // Behavioural reference model
  bit m_active = 0, m_seen = 0, m_take = 0;
  int m_need = 0, m_log = 0, m_done = 0, m_first = 0;
  int m_sum = 0, m_min = 0, m_max = 0;
  int e_cnt = 0, e_clip = 0, e_avg = 0, e_spread = 0;
  bit e_valid = 0, e_over = 0;
  int samples[$];

  always @(posedge clk) begin
    m_take = 0;
    e_valid = 0;
    if (!rst_n) begin
      m_active = 0; m_seen = 0; e_cnt = 0; e_clip = 0;
      e_avg = 0; e_spread = 0; e_over = 0;
    end else if (start) begin
      m_active = 1; m_log = log2_sweeps; m_need = 1 << log2_sweeps;
      m_done = 0; m_seen = 0; samples.delete();
    end else if (m_active && snap_valid) begin
      int n;
      bit hit;
      m_take = 1;
      n = 0;
      for (int i = 0; i < 16; i++)
        if (snap_row[base_pos + i] != snap_row[base_pos + i + 1]) n++;
      e_cnt = n;
      e_clip = (n > 15) ? 15 : n;
      hit = snap_row[base_pos + track_pair] != snap_row[base_pos + track_pair + 1];
      if (snap_last) begin
        samples.push_back(m_seen ? m_first : int'(snap_phase));
        m_seen = 0;
        m_done++;
        if (m_done == m_need) begin
          m_sum = 0; m_min = 4096; m_max = -1;
          foreach (samples[k]) begin
            m_sum += samples[k];
            if (samples[k] < m_min) m_min = samples[k];
            if (samples[k] > m_max) m_max = samples[k];
          end
          e_avg = m_sum / m_need;
          e_spread = m_max - m_min;
          e_over = e_spread > int'(spread_limit);
          e_valid = 1;
          m_active = 0;
        end
      end else if (hit && !m_seen) begin
        m_seen = 1;
        m_first = snap_phase;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!ended) begin
      chk("R3 snap_ready", snap_ready, (m_active && !start) ? 1 : 0);
      chk("R2 pair_diff_count", pair_diff_count, e_cnt);
      chk("R2 pair_diff_clip", pair_diff_clip, e_clip);
      chk("R6 avg_valid", avg_valid, e_valid);
      chk("R6 avg_out", avg_out, e_avg);
      chk("R7 spread_out", spread_out, e_spread);
      chk("R7 spread_over", spread_over, e_over);
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !ended) begin
      errors++;
      $display("FAIL R4 watchdog: cycles %0d expected below %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic begin_run(int lg, int pos, int tgt, int lim);
    step();
    start = 1; log2_sweeps = 3'(lg); base_pos = 8'(pos);
    track_pair = 4'(tgt); spread_limit = 11'(lim);
    step();
    start = 0;
  endtask

  // One sweep of n snapshots; the tracked pair differs from snapshot hit_at on.
  task automatic sweep(int n, int hit_at, int base_ph);
    for (int j = 0; j < n; j++) begin
      logic [271:0] r;
      for (int w = 0; w < 9; w++) r[w*32 +: 32] = $urandom;
      r[base_pos + track_pair + 1] = r[base_pos + track_pair] ^ (j >= hit_at);
      snap_row = r;
      snap_phase = 11'((base_ph + 37*j > 1120) ? 1120 : base_ph + 37*j);
      snap_last = (j == n - 1);
      snap_valid = 1;
      step();
      if ($urandom_range(0, 3) == 0) begin
        snap_valid = 0;
        step();
      end
    end
    snap_valid = 0;
    snap_last = 0;
  endtask

  task automatic full_run(int lg, int pos, int tgt, int lim, int nohit_pct);
    begin_run(lg, pos, tgt, lim);
    for (int s = 0; s < (1 << lg); s++) begin
      int n = $urandom_range(1, 4);
      int h = ($urandom_range(0, 99) < nohit_pct) ? n : $urandom_range(0, n - 1);
      sweep(n, h, $urandom_range(0, 1120));
    end
    step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;                                   // R8 reset values checked above
    step();
    // R3: offers while idle are ignored
    snap_row = {17{16'hA5A5}}; snap_valid = 1;
    repeat (3) step();
    snap_valid = 0;
    full_run(2, 0, 0, 100, 20);                  // R1 low window end
    full_run(0, 255, 15, 0, 0);                  // R1 high window end, R6 single sweep
    full_run(3, 100, 7, 2000, 60);               // R5 sweeps without a transition
    // R2 clip: alternating row gives 16 differing pairs
    begin_run(0, 40, 2, 10);
    snap_row = {136{2'b10}}; snap_phase = 11'd1120; snap_last = 1; snap_valid = 1;
    step();
    snap_valid = 0; snap_last = 0;
    step(); step();
    full_run(7, 37, 3, 5, 30);                   // R6 R7 longest run
    // R4 restart during a run while a snapshot is offered
    begin_run(2, 9, 11, 50);
    sweep(2, 0, 300);
    sweep(1, 1, 700);
    snap_valid = 1; snap_last = 1; snap_phase = 11'd5;
    start = 1; log2_sweeps = 3'd1;
    step();
    start = 0; snap_valid = 0; snap_last = 0;
    sweep(3, 1, 200);
    sweep(2, 2, 900);
    step(); step();
    full_run(1, 128, 0, 1200, 50);               // R8 hold checked by idle compare
    repeat (4) step();
    finish_run();
  end
endmodule